// File: doc/BRIEF.md
# Crystal Oscillator Mode Controller

This block sits beside the analog core of a low-frequency crystal oscillator. It holds two software-visible registers on a simple 32-bit bus. The control register carries the low-power policy bits, the master enable, the locking-loop enable and some bits that pass straight to the analog core. The tuning register carries two sets of amplifier bias codes: a run set and a sleep set.

From these registers and the chip's active-power indication, the block works out whether the oscillator runs in low-power mode. It then picks the 3-bit amplifier code and the 6-bit low-power code that go to the analog core. Low power can be forced by a bit, or it can follow the chip into DeepSleep when the automatic bit is set. DeepSleep is the state in which `act_pwr_en` is low; that input passes through a flop synchroniser before it is used.

The block also holds back the frequency-locking loop enable until the oscillator has settled. A down-counter, advanced by a one-cycle strobe from the low-frequency clock, starts from `SETTLE_TICKS` each time the master enable goes high. The loop enable is released only once that counter reaches zero.

Top module: `xosc_mode_ctrl`

## Requirements
- R1: After reset both registers read 0 and `lp_mode`, `amp_code`, `lp_code`, `osc_en`, `loop_en_q`, `ext_clk_en` and `test_bus` are all 0.
- R2: The control register is at offset 0x000 and has these fields: bit 0 force-low-power, bit 1 automatic low-power, bit 2 external clock enable, bits 15:8 test bits, bit 16 loop enable, bit 17 master enable. The tuning register is at offset 0x004 and has these fields: bits 2:0 run amplifier code, bits 13:8 run low-power code, bits 18:16 sleep amplifier code, bits 29:24 sleep low-power code. A write takes effect at the clock edge where `bus_we` is high. Reads are combinational. Bits outside the fields read 0.
- R3: A read of any other offset returns 0, and a write to any other offset leaves both registers unchanged.
- R4: `lp_mode` is 1 whenever the force bit is 1, whatever the other bits and `act_pwr_en` are.
- R5: When the force bit is 0, `lp_mode` equals the automatic bit ANDed with DeepSleep. DeepSleep means `act_pwr_en` is low. A change on `act_pwr_en` reaches the outputs after two clock edges and not after one.
- R6: When the automatic bit is 1 and the chip is in DeepSleep, `amp_code` and `lp_code` come from the sleep fields. Otherwise they come from the run fields, whatever the force bit is. Every amplifier code value 0 to 7, including 7 (zero bias current), passes through unchanged.
- R7: `osc_en` follows the master enable bit. Clearing the master enable drops both `osc_en` and `loop_en_q` at the same edge.
- R8: While the master enable is 0, the settle counter holds at `SETTLE_TICKS`. While it is 1, the counter drops by one on each clock edge where `lf_tick` is high, and it stops at 0. `loop_en_q` is 1 only when the loop enable bit is 1, the master enable is 1 and the counter is 0. It therefore rises at the edge that takes the `SETTLE_TICKS`-th strobe.
- R9: `ext_clk_en` and `test_bus` follow the external clock enable bit and the test bits of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| act_pwr_en | input | 1 | Active-power indication, asynchronous; low means DeepSleep |
| lf_tick | input | 1 | One-cycle strobe per low-frequency clock period |
| lp_mode | output | 1 | Resolved low-power mode |
| amp_code | output | 3 | Selected amplifier bias code |
| lp_code | output | 6 | Selected low-power bias code |
| osc_en | output | 1 | Oscillator enable (master enable) |
| loop_en_q | output | 1 | Qualified locking-loop enable |
| ext_clk_en | output | 1 | External clock input enable |
| test_bus | output | 8 | Test bits for the analog core |

## Verification
Register fields, and every output derived from them, change at the edge that captures the write, so they are sampled at the next falling edge. Reads are combinational and are sampled shortly after the address is set. A change on `act_pwr_en` needs two edges. The bench therefore checks `lp_mode` at the falling edge after one rising edge, where the old value must still show, and again after the second rising edge, where the new value must show. In the sweeps, `act_pwr_en` is given three edges to settle before checking. The loop enable is checked at the falling edge after the strobe that should complete the settle count, and also one strobe earlier, so an off-by-one in the count fails.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned AMP_W    = 3;
    localparam int unsigned LPC_W    = 6;
    localparam int unsigned TEST_W   = 8;
    localparam logic [31:0] OFS_CTRL = 32'h000;
    localparam logic [31:0] OFS_TUNE = 32'h004;

    typedef struct packed {
        logic              master_en;
        logic              loop_en;
        logic [TEST_W-1:0] test_bits;
        logic              ext_clk_en;
        logic              lp_auto;
        logic              lp_force;
    } ctrl_t;

    typedef struct packed {
        logic [LPC_W-1:0] lpc_sleep;
        logic [AMP_W-1:0] amp_sleep;
        logic [LPC_W-1:0] lpc_run;
        logic [AMP_W-1:0] amp_run;
    } tune_t;

    typedef struct packed {
        logic [AMP_W-1:0] amp;
        logic [LPC_W-1:0] lpc;
    } bias_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_TUNE = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        if (ofs == OFS_CTRL)      return SEL_CTRL;
        else if (ofs == OFS_TUNE) return SEL_TUNE;
        else                      return SEL_NONE;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.lp_force;
        w[1]     = c.lp_auto;
        w[2]     = c.ext_clk_en;
        w[15:8]  = c.test_bits;
        w[16]    = c.loop_en;
        w[17]    = c.master_en;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.lp_force   = w[0];
        c.lp_auto    = w[1];
        c.ext_clk_en = w[2];
        c.test_bits  = w[15:8];
        c.loop_en    = w[16];
        c.master_en  = w[17];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] tune_to_word(input tune_t t);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[2:0]   = t.amp_run;
        w[13:8]  = t.lpc_run;
        w[18:16] = t.amp_sleep;
        w[29:24] = t.lpc_sleep;
        return w;
    endfunction

    function automatic tune_t word_to_tune(input logic [DATA_W-1:0] w);
        tune_t t;
        t.amp_run   = w[2:0];
        t.lpc_run   = w[13:8];
        t.amp_sleep = w[18:16];
        t.lpc_sleep = w[29:24];
        return t;
    endfunction

endpackage

// File: rtl/xosc_regfile.sv
module xosc_regfile
    import xosc_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output tune_t             tune_q
);

    reg_sel_e sel;

    always_comb begin
        sel = decode_ofs(32'(addr));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tune_q <= '0;
        end else if (we) begin
            case (sel)
                SEL_CTRL: ctrl_q <= word_to_ctrl(wdata);
                SEL_TUNE: tune_q <= word_to_tune(wdata);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = ctrl_to_word(ctrl_q);
            SEL_TUNE: rdata = tune_to_word(tune_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/xosc_lp_policy.sv
module xosc_lp_policy
    import xosc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  act_pwr_en,
    input  logic  lp_force,
    input  logic  lp_auto,
    input  tune_t tune,
    output logic  deep_sleep,
    output logic  lp_mode,
    output bias_t bias
);

    logic [SYNC_STAGES-1:0] sync_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= act_pwr_en;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b1;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    logic use_sleep_set;

    always_comb begin
        deep_sleep    = ~sync_q[SYNC_STAGES-1];
        use_sleep_set = lp_auto & deep_sleep;
        lp_mode       = lp_force | use_sleep_set;
        if (use_sleep_set) begin
            bias.amp = tune.amp_sleep;
            bias.lpc = tune.lpc_sleep;
        end else begin
            bias.amp = tune.amp_run;
            bias.lpc = tune.lpc_run;
        end
    end

endmodule

// File: rtl/xosc_settle_timer.sv
module xosc_settle_timer #(
    parameter int unsigned SETTLE_TICKS = 16384,
    parameter int unsigned CNT_W        = $clog2(SETTLE_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_TICKS);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= LOAD;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/xosc_mode_ctrl.sv
module xosc_mode_ctrl
    import xosc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned SETTLE_TICKS = 16384,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              act_pwr_en,
    input  logic              lf_tick,
    output logic              lp_mode,
    output logic [2:0]        amp_code,
    output logic [5:0]        lp_code,
    output logic              osc_en,
    output logic              loop_en_q,
    output logic              ext_clk_en,
    output logic [7:0]        test_bus
);

    localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);

    ctrl_t            ctrl_q;
    tune_t            tune_q;
    bias_t            bias;
    logic             deep_sleep;
    logic [CNT_W-1:0] settle_cnt;
    logic             settled;

    xosc_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .tune_q (tune_q)
    );

    xosc_lp_policy #(.SYNC_STAGES(SYNC_STAGES)) u_policy (
        .clk        (clk),
        .rst        (rst),
        .act_pwr_en (act_pwr_en),
        .lp_force   (ctrl_q.lp_force),
        .lp_auto    (ctrl_q.lp_auto),
        .tune       (tune_q),
        .deep_sleep (deep_sleep),
        .lp_mode    (lp_mode),
        .bias       (bias)
    );

    xosc_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.master_en),
        .tick    (lf_tick),
        .cnt     (settle_cnt),
        .expired (settled)
    );

    always_comb begin
        amp_code   = bias.amp;
        lp_code    = bias.lpc;
        osc_en     = ctrl_q.master_en;
        loop_en_q  = ctrl_q.loop_en & ctrl_q.master_en & settled;
        ext_clk_en = ctrl_q.ext_clk_en;
        test_bus   = ctrl_q.test_bits;
    end

endmodule

// File: rtl/xosc_mode_ctrl_chk.sv
module xosc_mode_ctrl_chk #(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned SETTLE_TICKS = 16384,
    parameter int unsigned CNT_W        = 15
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              lp_force,
    input logic              lp_auto,
    input logic              loop_en,
    input logic              deep_sleep,
    input logic [2:0]        amp_run,
    input logic [2:0]        amp_sleep,
    input logic [2:0]        amp_code,
    input logic              lp_mode,
    input logic              osc_en,
    input logic              loop_en_q,
    input logic              lf_tick,
    input logic [CNT_W-1:0]  settle_cnt
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_TICKS);

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (32'(bus_addr) != 32'h0 && 32'(bus_addr) != 32'h4) |-> bus_rdata == 32'h0); // R3

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (rst)
        lp_force |-> lp_mode); // R4

    AST_AUTO_POLICY: assert property (@(posedge clk) disable iff (rst)
        !lp_force |-> (lp_mode == (lp_auto && deep_sleep))); // R5

    AST_SLEEP_SET: assert property (@(posedge clk) disable iff (rst)
        (lp_auto && deep_sleep) |-> amp_code == amp_sleep); // R6

    AST_RUN_SET: assert property (@(posedge clk) disable iff (rst)
        !(lp_auto && deep_sleep) |-> amp_code == amp_run); // R6

    AST_LOOP_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
        loop_en_q |-> (osc_en && loop_en)); // R7

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !osc_en |=> settle_cnt == LOAD); // R8

    AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (rst)
        (osc_en && !lf_tick) |=> $stable(settle_cnt)); // R8

    AST_LOOP_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        loop_en_q |-> settle_cnt == '0); // R8

endmodule

bind xosc_mode_ctrl xosc_mode_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .SETTLE_TICKS (SETTLE_TICKS),
    .CNT_W        (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .lp_force   (ctrl_q.lp_force),
    .lp_auto    (ctrl_q.lp_auto),
    .loop_en    (ctrl_q.loop_en),
    .deep_sleep (deep_sleep),
    .amp_run    (tune_q.amp_run),
    .amp_sleep  (tune_q.amp_sleep),
    .amp_code   (amp_code),
    .lp_mode    (lp_mode),
    .osc_en     (osc_en),
    .loop_en_q  (loop_en_q),
    .lf_tick    (lf_tick),
    .settle_cnt (settle_cnt)
);

// File: tb/tb_xosc_mode_ctrl.sv
module tb_xosc_mode_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int SETTLE     = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              act_pwr_en = 1'b1;
    logic              lf_tick = 1'b0;
    logic              lp_mode;
    logic [2:0]        amp_code;
    logic [5:0]        lp_code;
    logic              osc_en;
    logic              loop_en_q;
    logic              ext_clk_en;
    logic [7:0]        test_bus;

    int n_checks = 0;
    int n_fail   = 0;

    xosc_mode_ctrl #(.ADDR_W(ADDR_W), .SETTLE_TICKS(SETTLE), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_pwr_en(act_pwr_en),
        .lf_tick(lf_tick), .lp_mode(lp_mode), .amp_code(amp_code),
        .lp_code(lp_code), .osc_en(osc_en), .loop_en_q(loop_en_q),
        .ext_clk_en(ext_clk_en), .test_bus(test_bus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        lf_tick = 1'b1;
        @(negedge clk);
        lf_tick = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic f, input logic a, input logic ext,
                                             input logic [7:0] tb, input logic le, input logic me);
        return {14'd0, me, le, tb, 5'd0, ext, a, f};
    endfunction

    function automatic logic [31:0] tune_word(input logic [2:0] ar, input logic [5:0] lr,
                                             input logic [2:0] as, input logic [5:0] ls);
        return {2'd0, ls, 5'd0, as, 2'd0, lr, 5'd0, ar};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] ctrl_saved, tune_saved;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(12'h000, rd); check("R1 ctrl", rd, 0);
        bus_read(12'h004, rd); check("R1 tune", rd, 0);
        check("R1 outputs", {lp_mode, amp_code, lp_code, osc_en, loop_en_q, ext_clk_en, test_bus},
              0);

        // R2 field readback
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_read(12'h000, rd); check("R2 ctrl all-ones", rd, 32'h0003_FF07);
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_read(12'h004, rd); check("R2 tune all-ones", rd, 32'h3F07_3F07);
        bus_write(12'h004, tune_word(3'd5, 6'd42, 3'd2, 6'd17));
        bus_read(12'h004, rd); check("R2 tune pattern", rd, 32'h1102_2A05);

        // R9 pass-through
        bus_write(12'h000, ctrl_word(0, 0, 1, 8'hA5, 0, 0));
        check("R9 ext_clk_en", {31'd0, ext_clk_en}, 1);
        check("R9 test_bus", {24'd0, test_bus}, 32'hA5);
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h3C, 0, 0));
        check("R9 ext_clk_en clear", {31'd0, ext_clk_en}, 0);
        check("R9 test_bus 3C", {24'd0, test_bus}, 32'h3C);

        // R3 unmapped access
        bus_read(12'h000, ctrl_saved);
        bus_read(12'h004, tune_saved);
        bus_write(12'h008, 32'hFFFF_FFFF);
        bus_write(12'hFFC, 32'hFFFF_FFFF);
        bus_write(12'h001, 32'hFFFF_FFFF);
        bus_read(12'h000, rd); check("R3 ctrl untouched", rd, ctrl_saved);
        bus_read(12'h004, rd); check("R3 tune untouched", rd, tune_saved);
        bus_read(12'h008, rd); check("R3 read 0x008", rd, 0);
        bus_read(12'hF00, rd); check("R3 read 0xF00", rd, 0);

        // R4 R5 R6 sweep over force, auto, power state and all amp codes
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < 2; a++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int k = 0; k < 8; k++) begin
                        logic [2:0] ar, as;
                        logic [5:0] lr, ls;
                        logic       sel, exp_lp;
                        ar = 3'(k); as = 3'(7 - k);
                        lr = 6'(k * 5 + 1); ls = 6'(63 - k * 3);
                        bus_write(12'h000, ctrl_word(f[0], a[0], 0, 8'h00, 0, 0));
                        bus_write(12'h004, tune_word(ar, lr, as, ls));
                        @(negedge clk);
                        act_pwr_en = p[0];
                        repeat (3) @(posedge clk);
                        @(negedge clk);
                        sel    = a[0] & ~p[0];
                        exp_lp = f[0] | sel;
                        if (f[0]) check("R4 forced lp_mode", {31'd0, lp_mode}, {31'd0, exp_lp});
                        else      check("R5 auto lp_mode", {31'd0, lp_mode}, {31'd0, exp_lp});
                        check("R6 amp_code", {29'd0, amp_code}, {29'd0, sel ? as : ar});
                        check("R6 lp_code", {26'd0, lp_code}, {26'd0, sel ? ls : lr});
                    end
                end
            end
        end

        // R5 synchroniser latency: two edges, not one
        @(negedge clk); act_pwr_en = 1'b1;
        bus_write(12'h000, ctrl_word(0, 1, 0, 8'h00, 0, 0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        act_pwr_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R5 latency one edge", {31'd0, lp_mode}, 0);
        @(posedge clk); @(negedge clk);
        check("R5 latency two edges", {31'd0, lp_mode}, 1);
        act_pwr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R5 exit one edge", {31'd0, lp_mode}, 1);
        @(posedge clk); @(negedge clk);
        check("R5 exit two edges", {31'd0, lp_mode}, 0);

        // R8 ticks while master off have no effect
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h00, 1, 0));
        for (int i = 0; i < SETTLE + 2; i++) pulse_tick();
        check("R8 master off loop", {31'd0, loop_en_q}, 0);

        // R7 R8 settle count
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h00, 1, 1));
        check("R7 osc_en set", {31'd0, osc_en}, 1);
        check("R8 loop held at start", {31'd0, loop_en_q}, 0);
        for (int i = 0; i < SETTLE - 1; i++) pulse_tick();
        check("R8 loop held one tick early", {31'd0, loop_en_q}, 0);
        pulse_tick();
        check("R8 loop released", {31'd0, loop_en_q}, 1);
        pulse_tick();
        check("R8 loop stays after extra tick", {31'd0, loop_en_q}, 1);

        // R8 loop enable bit gates the output
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h00, 0, 1));
        check("R8 loop bit off", {31'd0, loop_en_q}, 0);
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h00, 1, 1));
        check("R8 loop bit back on", {31'd0, loop_en_q}, 1);

        // R7 clearing master drops both
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h00, 1, 0));
        check("R7 osc_en clear", {31'd0, osc_en}, 0);
        check("R7 loop dropped", {31'd0, loop_en_q}, 0);

        // R8 re-enable restarts the full count
        bus_write(12'h000, ctrl_word(0, 0, 0, 8'h00, 1, 1));
        check("R8 restart held", {31'd0, loop_en_q}, 0);
        for (int i = 0; i < SETTLE - 1; i++) pulse_tick();
        check("R8 restart one early", {31'd0, loop_en_q}, 0);
        pulse_tick();
        check("R8 restart released", {31'd0, loop_en_q}, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule